// File: doc/BRIEF.md
# Dual-Channel Serial ADC Readout Controller

This block sits on the host side of a two-channel, simultaneous-sampling serial ADC. It runs from the system clock. It drives the converter's active-low chip select and its serial clock, and it collects the two conversion results from the converter's serial data lines. Pulling chip select low starts a conversion on both channels and also opens the serial frame. The serial clock clocks the conversion as well, so it runs without a pause from the first falling edge to the last rising edge of the frame.

The converter changes its data on each serial-clock falling edge. The controller samples each data line in the system-clock cycle where it drives the serial clock high again.

There are three frame layouts:

- **Short frame:** 16 serial clocks. Each line carries its own channel's result.
- **Long frame:** 18 serial clocks. Each line carries its own channel's result, followed by extra zero bits.
- **Chained frame:** 36 serial clocks on line A only. Channel A's 18-bit slot comes first, then channel B's.

The layout and the half-period divider are taken at the start pulse. When chip select returns high, both results are presented with a one-cycle valid strobe and a framing-error flag. A minimum chip-select-high time between frames can be set.

Top module: `adc_pair_reader`

## Requirements
- R1: While reset is held and after it is released with no start, `cs_n` is 1, `sclk` is 1, `busy` is 0 and `valid` is 0.
- R2: A `start` pulse that is accepted pulls `cs_n` low on the next clock. `busy` then stays 1 for exactly the cycles in which `cs_n` is low.
- R3: `sclk` is 1 whenever `cs_n` is 1. The frame's timing uses D = `half_div`, with 0 treated as 1:
  - the first `sclk` fall comes D clocks after `cs_n` falls;
  - every later `sclk` edge comes D clocks after the previous edge;
  - `cs_n` rises D clocks after the last `sclk` rise.
- R4: The `mode` input sets the number of `sclk` falling edges in a frame:
  - 2'b00 gives 16;
  - 2'b01 gives 18;
  - 2'b10 gives 36;
  - 2'b11 behaves as 2'b00.
- R5: Sample position k counts from 0 and is taken at the (k+1)-th `sclk` rise. Positions 1 to 14 of a result slot carry the 14 result bits, MSB first. Position 0 is a leading zero, and every remaining position of the slot is a zero.
- R6: In modes 2'b00, 2'b01 and 2'b11, `res_a` is taken from `sdo_a` and `res_b` from `sdo_b`, in the same frame.
- R7: In mode 2'b10, `res_a` comes from `sdo_a` positions 1 to 14 and `res_b` from `sdo_a` positions 19 to 32. `sdo_b` has no effect on the results or on `frame_err`.
- R8: `valid` is a single-cycle pulse in the cycle where `cs_n` returns to 1. `res_a`, `res_b` and `frame_err` change only with `valid` and hold until the next pulse.
- R9: `frame_err` is 1 with `valid` if any sampled non-data position on a checked line was 1, and 0 otherwise.
- R10: Once `cs_n` has gone high after a frame, a `start` is accepted only when `cs_n` has been high for at least max(`gap_min`,1) clocks. A start that comes earlier is dropped and not held over.
- R11: A `start` that arrives while `busy` is 1 is ignored.
- R12: `mode` and `half_div` are latched when a start is accepted. Changing them during a frame does not alter that frame's length, layout or timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one transfer |
| mode | input | 2 | Frame layout select |
| half_div | input | DIV_W | Serial-clock half-period in system clocks (0 acts as 1) |
| gap_min | input | GAP_W | Minimum chip-select-high clocks between frames |
| cs_n | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter, idles high |
| sdo_a | input | 1 | Serial data line A |
| sdo_b | input | 1 | Serial data line B |
| busy | output | 1 | Transfer in progress |
| valid | output | 1 | One-cycle strobe: results are new |
| res_a | output | DATA_W | Channel A result |
| res_b | output | DATA_W | Channel B result |
| frame_err | output | 1 | A non-data position read as 1 |

## Verification
The bound checker watches the following on every cycle:

- the serial clock stays high outside frames;
- `busy` mirrors chip select;
- the valid strobe coincides with the chip-select rise and is a single-cycle pulse;
- the number of falling edges matches the mode latched at the accepted start;
- the chip-select-high gap is respected.

Some properties need known stimulus, and only the bench scenarios can show them:

- bit order and channel routing;
- framing-error detection, including line B being ignored in the chained layout;
- the exact half-period spacing for several dividers, including zero;
- the dropping of early and mid-frame starts.

// File: rtl/adc_rd_pkg.sv
// Package adc_rd_pkg
// Shared encodings for the dual-channel ADC readout controller.
// Assumes: the mode encoding below is what the host drives on the mode pins.
package adc_rd_pkg;

    // Frame layout requested by the host; RSVD is handled like SHORT.
    typedef enum logic [1:0] {
        FM_SHORT = 2'b00,
        FM_LONG  = 2'b01,
        FM_CHAIN = 2'b10,
        FM_RSVD  = 2'b11
    } frame_mode_e;

    // Phases of one transfer as seen on the converter pins.
    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LEAD,
        SQ_LOW,
        SQ_HIGH,
        SQ_TAIL
    } seq_state_e;

endpackage

// File: rtl/adc_rd_gap_timer.sv
// Module adc_rd_gap_timer
// Counts system clocks that chip select has been high since the last frame
// ended and reports when the programmed minimum gap has been met.
// Assumes: frame_done is a one-cycle pulse on the edge that raises cs_n.
module adc_rd_gap_timer #(
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             frame_done,
    input  logic [GAP_W-1:0] gap_min,
    output logic             gap_ok
);

    localparam logic [GAP_W-1:0] GAP_SAT = {GAP_W{1'b1}};

    logic [GAP_W-1:0] gcnt;

    // Restart at one when chip select rises, then count idle clocks up to saturation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gcnt <= '0;
        end else if (frame_done) begin
            gcnt <= GAP_W'(1);
        end else if (cs_n && gcnt != GAP_SAT) begin
            gcnt <= gcnt + GAP_W'(1);
        end
    end

    assign gap_ok = cs_n && (gcnt >= gap_min);

endmodule

// File: rtl/adc_rd_sequencer.sv
// Module adc_rd_sequencer
// Generates chip select and the serial clock for one frame.
// The serial clock idles high and each phase lasts div_q system clocks.
// A sample strobe is raised in the cycle that drives the serial clock high.
// Assumes: start is evaluated only when idle, and the mode and divider
// inputs are latched at that moment.
module adc_rd_sequencer
    import adc_rd_pkg::*;
#(
    parameter int DATA_W = 14,
    parameter int DIV_W  = 8,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              gap_ok,
    input  logic [1:0]        mode_in,
    input  logic [DIV_W-1:0]  half_div,
    output logic              cs_n,
    output logic              sclk,
    output logic              busy,
    output logic              smp,
    output logic [CNT_W-1:0]  bit_idx,
    output logic              chain,
    output logic              frame_start,
    output logic              frame_done
);

    localparam int LEN_SHORT = DATA_W + 2;
    localparam int LEN_LONG  = DATA_W + 4;
    localparam int LEN_CHAIN = 2 * LEN_LONG;

    seq_state_e       st;
    frame_mode_e      mode_q;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] hcnt;
    logic [CNT_W-1:0] bitcnt;
    logic [CNT_W-1:0] last_bit;
    logic             last_half;

    // Clamp a zero divider to one system clock per half period.
    assign div_eff = (half_div == '0) ? DIV_W'(1) : half_div;

    // Index of the final sample position for the latched layout.
    always_comb begin
        case (mode_q)
            FM_LONG:  last_bit = CNT_W'(LEN_LONG - 1);
            FM_CHAIN: last_bit = CNT_W'(LEN_CHAIN - 1);
            default:  last_bit = CNT_W'(LEN_SHORT - 1);
        endcase
    end

    assign last_half   = (hcnt == div_q - DIV_W'(1));
    assign frame_start = (st == SQ_IDLE) && start && gap_ok;
    assign frame_done  = (st == SQ_TAIL) && last_half;
    assign smp         = (st == SQ_LOW) && last_half;
    assign bit_idx     = bitcnt;
    assign chain       = (mode_q == FM_CHAIN);

    // Step through lead-in, clock phases and tail; own cs_n, sclk and busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            cs_n   <= 1'b1;
            sclk   <= 1'b1;
            busy   <= 1'b0;
            hcnt   <= '0;
            bitcnt <= '0;
            mode_q <= FM_SHORT;
            div_q  <= DIV_W'(1);
        end else begin
            case (st)
                SQ_IDLE: begin
                    if (frame_start) begin
                        cs_n   <= 1'b0;
                        busy   <= 1'b1;
                        mode_q <= frame_mode_e'(mode_in);
                        div_q  <= div_eff;
                        hcnt   <= '0;
                        bitcnt <= '0;
                        st     <= SQ_LEAD;
                    end
                end
                SQ_LEAD: begin
                    if (last_half) begin
                        sclk <= 1'b0;
                        hcnt <= '0;
                        st   <= SQ_LOW;
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                SQ_LOW: begin
                    if (last_half) begin
                        sclk   <= 1'b1;
                        hcnt   <= '0;
                        bitcnt <= bitcnt + CNT_W'(1);
                        st     <= (bitcnt == last_bit) ? SQ_TAIL : SQ_HIGH;
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                SQ_HIGH: begin
                    if (last_half) begin
                        sclk <= 1'b0;
                        hcnt <= '0;
                        st   <= SQ_LOW;
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                SQ_TAIL: begin
                    if (last_half) begin
                        cs_n <= 1'b1;
                        busy <= 1'b0;
                        hcnt <= '0;
                        st   <= SQ_IDLE;
                    end else begin
                        hcnt <= hcnt + DIV_W'(1);
                    end
                end
                default: st <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_rd_capture.sv
// Module adc_rd_capture
// Shifts result bits in at each sample strobe, checks the non-data
// positions for zeros and publishes both results with a valid pulse.
// Assumes: bit_idx is the position of the sample being taken, and in
// chained mode the second slot starts DATA_W+4 positions after the first.
module adc_rd_capture #(
    parameter int DATA_W = 14,
    parameter int CNT_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              smp,
    input  logic [CNT_W-1:0]  bit_idx,
    input  logic              chain,
    input  logic              sdo_a,
    input  logic              sdo_b,
    output logic              valid,
    output logic [DATA_W-1:0] res_a,
    output logic [DATA_W-1:0] res_b,
    output logic              frame_err
);

    localparam int SLOT    = DATA_W + 4;
    localparam int A_FIRST = 1;
    localparam int A_LAST  = DATA_W;
    localparam int B_FIRST = SLOT + 1;
    localparam int B_LAST  = SLOT + DATA_W;

    logic [DATA_W-1:0] sh_a;
    logic [DATA_W-1:0] sh_b;
    logic              err_acc;
    logic              in_a;
    logic              in_b;
    logic              line_b_in;
    logic              zero_bad;

    // Decode which slot, if any, the current position belongs to.
    assign in_a      = (bit_idx >= CNT_W'(A_FIRST)) && (bit_idx <= CNT_W'(A_LAST));
    assign in_b      = chain && (bit_idx >= CNT_W'(B_FIRST)) && (bit_idx <= CNT_W'(B_LAST));
    assign line_b_in = chain ? sdo_a : sdo_b;
    assign zero_bad  = sdo_a || (!chain && sdo_b);

    // Shift data bits MSB first and accumulate framing faults.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_a    <= '0;
            sh_b    <= '0;
            err_acc <= 1'b0;
        end else if (frame_start) begin
            err_acc <= 1'b0;
        end else if (smp) begin
            if (in_a) begin
                sh_a <= {sh_a[DATA_W-2:0], sdo_a};
                if (!chain) begin
                    sh_b <= {sh_b[DATA_W-2:0], line_b_in};
                end
            end else if (in_b) begin
                sh_b <= {sh_b[DATA_W-2:0], line_b_in};
            end else if (zero_bad) begin
                err_acc <= 1'b1;
            end
        end
    end

    // Publish results and the error flag when chip select rises.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid     <= 1'b0;
            res_a     <= '0;
            res_b     <= '0;
            frame_err <= 1'b0;
        end else begin
            valid <= frame_done;
            if (frame_done) begin
                res_a     <= sh_a;
                res_b     <= sh_b;
                frame_err <= err_acc;
            end
        end
    end

endmodule

// File: rtl/adc_pair_reader.sv
// Module adc_pair_reader
// Top level of the dual-channel ADC readout controller.
// It joins the gap timer, the pin sequencer and the capture path.
// Assumes: sdo_a and sdo_b are already synchronous to clk, which holds
// because they change only after sclk falls and sclk comes from clk.
module adc_pair_reader #(
    parameter int DATA_W = 14,
    parameter int DIV_W  = 8,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        mode,
    input  logic [DIV_W-1:0]  half_div,
    input  logic [GAP_W-1:0]  gap_min,
    output logic              cs_n,
    output logic              sclk,
    input  logic              sdo_a,
    input  logic              sdo_b,
    output logic              busy,
    output logic              valid,
    output logic [DATA_W-1:0] res_a,
    output logic [DATA_W-1:0] res_b,
    output logic              frame_err
);

    localparam int CNT_W = $clog2(2 * (DATA_W + 4) + 1);

    logic             gap_ok;
    logic             smp;
    logic [CNT_W-1:0] bit_idx;
    logic             chain;
    logic             frame_start;
    logic             frame_done;

    adc_rd_gap_timer #(.GAP_W(GAP_W)) u_gap (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .frame_done (frame_done),
        .gap_min    (gap_min),
        .gap_ok     (gap_ok)
    );

    adc_rd_sequencer #(.DATA_W(DATA_W), .DIV_W(DIV_W), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .gap_ok      (gap_ok),
        .mode_in     (mode),
        .half_div    (half_div),
        .cs_n        (cs_n),
        .sclk        (sclk),
        .busy        (busy),
        .smp         (smp),
        .bit_idx     (bit_idx),
        .chain       (chain),
        .frame_start (frame_start),
        .frame_done  (frame_done)
    );

    adc_rd_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .smp         (smp),
        .bit_idx     (bit_idx),
        .chain       (chain),
        .sdo_a       (sdo_a),
        .sdo_b       (sdo_b),
        .valid       (valid),
        .res_a       (res_a),
        .res_b       (res_b),
        .frame_err   (frame_err)
    );

endmodule

// File: rtl/adc_pair_reader_chk.sv
// Module adc_pair_reader_chk
// Protocol checker bound to adc_pair_reader.
// It watches pin-level rules of the frame on every clock.
// Assumes: mode and gap_min are sampled by the host at its own start pulse.
module adc_pair_reader_chk #(
    parameter int DATA_W = 14,
    parameter int GAP_W  = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [1:0]       mode,
    input logic [GAP_W-1:0] gap_min,
    input logic             cs_n,
    input logic             sclk,
    input logic             busy,
    input logic             valid
);

    localparam int CNT_W = $clog2(2 * (DATA_W + 4) + 1);
    localparam logic [GAP_W:0] HI_SAT = {(GAP_W+1){1'b1}};

    logic [1:0]       pend_mode;
    logic [CNT_W-1:0] fall_cnt;
    logic [CNT_W-1:0] exp_len;
    logic             sclk_q;
    logic [GAP_W:0]   hi_cnt;
    logic             seen_frame;

    // Remember the mode of the most recent start seen while deselected.
    always_ff @(posedge clk) begin
        if (!rst_n)              pend_mode <= 2'b00;
        else if (cs_n && start)  pend_mode <= mode;
    end

    // Count serial-clock falling edges inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            fall_cnt <= '0;
        end else begin
            sclk_q <= sclk;
            if (cs_n)                fall_cnt <= '0;
            else if (sclk_q && !sclk) fall_cnt <= fall_cnt + CNT_W'(1);
        end
    end

    // Count chip-select-high clocks and note that a frame has completed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt     <= '0;
            seen_frame <= 1'b0;
        end else begin
            if (!cs_n)               hi_cnt <= '0;
            else if (hi_cnt != HI_SAT) hi_cnt <= hi_cnt + (GAP_W+1)'(1);
            if (valid)               seen_frame <= 1'b1;
        end
    end

    // Expected falling-edge count from the remembered mode.
    always_comb begin
        case (pend_mode)
            2'b01:   exp_len = CNT_W'(DATA_W + 4);
            2'b10:   exp_len = CNT_W'(2 * (DATA_W + 4));
            default: exp_len = CNT_W'(DATA_W + 2);
        endcase
    end

    a_r3_sclk_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> sclk);

    a_r2_busy_tracks_cs: assert property (@(posedge clk) disable iff (!rst_n)
        busy != cs_n);

    a_r8_valid_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r8_valid_at_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> valid);

    a_r8_valid_only_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $rose(cs_n));

    a_r4_frame_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> (fall_cnt == exp_len));

    a_r10_min_gap: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cs_n) && seen_frame) |-> ((hi_cnt >= {1'b0, gap_min}) && (hi_cnt != '0)));

endmodule

bind adc_pair_reader adc_pair_reader_chk #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .gap_min (gap_min),
    .cs_n    (cs_n),
    .sclk    (sclk),
    .busy    (busy),
    .valid   (valid)
);

// File: tb/test_adc_pair_reader.sv
// Scoreboard bench for adc_pair_reader, with a behavioural converter model.
module test_adc_pair_reader;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 14;
    localparam int DIV_W  = 8;
    localparam int GAP_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        mode = 2'b00;
    logic [DIV_W-1:0]  half_div = 8'd1;
    logic [GAP_W-1:0]  gap_min = 8'd0;
    logic              cs_n;
    logic              sclk;
    logic              sdo_a = 1'b0;
    logic              sdo_b = 1'b0;
    logic              busy;
    logic              valid;
    logic [DATA_W-1:0] res_a;
    logic [DATA_W-1:0] res_b;
    logic              frame_err;

    int nchk = 0;
    int nerr = 0;

    typedef struct {
        logic [DATA_W-1:0] a;
        logic [DATA_W-1:0] b;
        logic              err;
        int                len;
        int                div;
    } exp_t;

    exp_t exq[$];

    logic [35:0] str_a = '0;
    logic [35:0] str_b = '0;
    int          fidx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_pair_reader #(.DATA_W(DATA_W), .DIV_W(DIV_W), .GAP_W(GAP_W)) i_adc_pair_reader (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .half_div(half_div), .gap_min(gap_min), .cs_n(cs_n), .sclk(sclk),
        .sdo_a(sdo_a), .sdo_b(sdo_b), .busy(busy), .valid(valid),
        .res_a(res_a), .res_b(res_b), .frame_err(frame_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Converter model: the next bit appears at each sclk fall, position 0 first.
    always @(negedge sclk or posedge cs_n) begin
        if (cs_n) begin
            fidx  <= 0;
            sdo_a <= 1'b0;
            sdo_b <= 1'b0;
        end else if (fidx < 36) begin
            sdo_a <= str_a[35 - fidx];
            sdo_b <= str_b[35 - fidx];
            fidx  <= fidx + 1;
        end
    end

    // Monitor: edge spacing, falling-edge count, gap and the results.
    logic pcs = 1'b1;
    logic psclk = 1'b1;
    int   since = 0;
    int   falls = 0;
    int   tbad = 0;
    int   hi = 0;
    int   frames = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            int dv;
            dv = (exq.size() > 0) ? exq[0].div : 1;
            since++;
            if (pcs && !cs_n) begin
                if (frames > 0) begin
                    // R10: minimum chip-select-high time before an accepted start
                    check(hi >= ((gap_min == 0) ? 1 : int'(gap_min)), "R10", "cs_n high clocks", hi, gap_min);
                end
                since = 0;
                falls = 0;
                hi = 0;
            end else if ((!cs_n && (sclk != psclk)) || (!pcs && cs_n)) begin
                if (since != dv) tbad++;
                since = 0;
            end
            if (!cs_n && psclk && !sclk) falls++;
            if (cs_n) hi++;
            if (valid) begin
                frames++;
                check(cs_n && !pcs, "R8", "valid with cs_n rise", cs_n, 1);
                if (exq.size() == 0) begin
                    check(1'b0, "R11", "unexpected valid", 1, 0);
                end else begin
                    exp_t e;
                    e = exq.pop_front();
                    check(res_a == e.a, "R5/R6/R7", "res_a", res_a, e.a);
                    check(res_b == e.b, "R6/R7", "res_b", res_b, e.b);
                    check(frame_err == e.err, "R9", "frame_err", frame_err, e.err);
                    check(falls == e.len, "R4", "sclk falls", falls, e.len);
                    check(tbad == 0, "R3", "edge spacing faults", tbad, 0);
                end
                tbad = 0;
            end
            pcs   = cs_n;
            psclk = sclk;
        end
    end

    // Driver: build the streams, push the expected item and pulse start.
    task automatic run_frame(input logic [1:0] m, input logic [DATA_W-1:0] wa,
                             input logic [DATA_W-1:0] wb, input int flip_a,
                             input int flip_b, input logic [DIV_W-1:0] dv,
                             input bit poke);
        exp_t e;
        while (busy) @(negedge clk);
        repeat (int'(gap_min) + 2) @(negedge clk);
        if (m == 2'b10) begin
            str_a = {1'b0, wa, 3'b000, 1'b0, wb, 3'b000};
            str_b = '1;
        end else begin
            str_a = {1'b0, wa, 21'd0};
            str_b = {1'b0, wb, 21'd0};
        end
        if (flip_a >= 0) str_a[35 - flip_a] = ~str_a[35 - flip_a];
        if (flip_b >= 0) str_b[35 - flip_b] = ~str_b[35 - flip_b];
        e.a   = wa;
        e.b   = wb;
        e.err = (flip_a >= 0) || ((m != 2'b10) && (flip_b >= 0));
        e.len = (m == 2'b10) ? 36 : (m == 2'b01) ? 18 : 16;
        e.div = (dv == 0) ? 1 : int'(dv);
        exq.push_back(e);
        mode     = m;
        half_div = dv;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // R2: chip select falls on the clock after the accepted start
        check(!cs_n && busy, "R2", "cs_n low after start", cs_n, 0);
        if (poke) begin
            repeat (10) @(negedge clk);
            mode     = ~m;
            half_div = 8'd5;
            start    = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: idle pin levels under reset
        check(cs_n == 1'b1 && sclk == 1'b1, "R1", "pins in reset", {cs_n, sclk}, 2'b11);
        check(busy == 1'b0 && valid == 1'b0, "R1", "busy/valid in reset", {busy, valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(cs_n && sclk && !busy && !valid, "R1", "idle after reset", {cs_n, sclk, busy, valid}, 4'b1100);

        run_frame(2'b00, 14'h2A5C, 14'h1337, -1, -1, 8'd1, 0);   // R5 R6
        run_frame(2'b01, 14'h3FFF, 14'h0001, -1, -1, 8'd2, 0);   // R4 long frame
        run_frame(2'b10, 14'h0F0F, 14'h30C3, -1, -1, 8'd1, 0);   // R7 chained
        run_frame(2'b11, 14'h1234, 14'h2DCB, -1, -1, 8'd0, 0);   // R3 zero divider, R4 reserved
        run_frame(2'b00, 14'h0AAA, 14'h1555, 0, -1, 8'd3, 0);    // R9 leading bit
        run_frame(2'b01, 14'h0101, 14'h2020, -1, 17, 8'd1, 0);   // R9 trailing on line B
        run_frame(2'b10, 14'h3333, 14'h0CCC, -1, 5, 8'd1, 0);    // R7 line B ignored
        run_frame(2'b10, 14'h1111, 14'h2222, 18, -1, 8'd2, 0);   // R9 second leading zero
        run_frame(2'b10, 14'h0777, 14'h3888, 34, -1, 8'd1, 0);   // R9 chained trailing zero

        // R8: results hold after the pulse
        repeat (5) @(negedge clk);
        check(res_a == 14'h0777 && res_b == 14'h3888 && !valid, "R8", "held results", res_a, 14'h0777);

        // R10: early start dropped
        gap_min = 8'd6;
        run_frame(2'b00, 14'h0055, 14'h00AA, -1, -1, 8'd1, 0);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        begin
            bit stayed = 1'b1;
            for (int i = 0; i < 10; i++) begin
                if (!cs_n) stayed = 1'b0;
                @(negedge clk);
            end
            check(stayed, "R10", "early start ignored", stayed, 1);
        end
        run_frame(2'b01, 14'h1F00, 14'h00F1, -1, -1, 8'd1, 0);

        // R11, R12: mid-frame start and input changes
        run_frame(2'b00, 14'h2468, 14'h1357, -1, -1, 8'd2, 1);
        repeat (20) @(negedge clk);
        check(cs_n && !busy, "R11", "no frame from busy start", {cs_n, busy}, 2'b10);
        run_frame(2'b10, 14'h3C3C, 14'h03C3, -1, -1, 8'd1, 1);  // R12 chained kept
        repeat (20) @(negedge clk);
        check(exq.size() == 0, "R12", "scoreboard drained", exq.size(), 0);

        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

endmodule